// File: doc/BRIEF.md
# Completion Interrupt Coalescing Timer

Each DMA channel carries one copy of this unit. It watches the stream of descriptor completions and turns those whose descriptor asked for an interrupt into a single, delayed interrupt request. The first such completion after an idle period opens a window whose length is a programmed number of microseconds. Later flagged completions inside the window are only counted. When the window runs out, the level interrupt request goes high and stays high until software acknowledges it.

Time is measured in pulses of a one-microsecond tick input, so the window length does not depend on the clock frequency. The delay register holds values from 0 to 16383 microseconds. A delay of zero sends every flagged completion straight to the interrupt. A count of the merged completions goes out with the request, so the handler knows how many descriptors it is serving. A constant output reports the largest delay the unit accepts. No state is shared between channels.

Top module: `irq_coalesce_timer`

## Requirements
- R1: After reset, irq_req is 0, merged_cnt is 0 and the delay register holds 0.
- R2: max_delay always reads 16383, which is 2^14 - 1 for the 14-bit delay field.
- R3: A completion with cmpl_irq_en = 0 has no effect in any state. It does not arm a window, does not change merged_cnt and does not raise irq_req.
- R4: A flagged completion (cmpl_valid = 1 and cmpl_irq_en = 1) while idle opens a window of D ticks, where D is the programmed delay. A tick in the arming cycle does not count. irq_req goes high on the clock edge that samples the D-th later us_tick, and merged_cnt reads 1 after arming.
- R5: Flagged completions while a window is open or the request is pending add 1 each to merged_cnt and never restart the window.
- R6: With a programmed delay of 0, irq_req goes high on the clock edge that samples the arming flagged completion.
- R7: irq_req stays high until irq_ack is sampled while it is high. irq_ack sampled while irq_req is low has no effect.
- R8: An acknowledge with no flagged completion in the same cycle drops irq_req and clears merged_cnt to 0 on that edge.
- R9: An acknowledge that coincides with a flagged completion opens a new window and sets merged_cnt to 1. With delay 0, irq_req stays high.
- R10: merged_cnt saturates at 2^CNT_W - 1 (255 by default).
- R11: A delay written while a window is open takes effect only from the next window.
- R12: Clock cycles without us_tick never advance the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_valid | input | 1 | One-cycle strobe: a descriptor completed |
| cmpl_irq_en | input | 1 | Interrupt-enable flag of that descriptor |
| delay_wr | input | 1 | Write strobe for the delay register |
| delay_wdata | input | DLY_W (14) | New delay in microseconds |
| us_tick | input | 1 | One-cycle pulse, once per microsecond |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_req | output | 1 | Level interrupt request |
| merged_cnt | output | CNT_W (8) | Flagged completions merged into the current request |
| max_delay | output | DLY_W (14) | Largest supported delay |

## Verification
The main path is driven with bursts of flagged completions mixed with ticks. The first completion arrives in the same cycle as a tick, and later completions fall between ticks. The window ends on exactly the D-th tick only if that tick in the arming cycle is not counted and the later completions do not restart the timer. Long gaps without ticks show that the window runs on ticks and not on clock cycles. Unflagged completions, acknowledges while no request is pending, and delay writes during a window are each shown to leave the count and the request as they were. Acknowledges that coincide with a completion separate a clean clear from a restart. The delay extremes (0 and 16383) and a run of 300 completions test immediate firing, the full window and counter saturation.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_ARMED = 2'd1,
    CH_FIRED = 2'd2
  } coal_state_e;

  // all-ones value of a field of width w
  function automatic int unsigned field_top(input int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction
endpackage

// File: rtl/irqc_delay_reg.sv
`timescale 1ns/1ps
module irqc_delay_reg #(
  parameter int unsigned DLY_W     = 14,
  parameter int unsigned RESET_DLY = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DLY_W-1:0] wr_val,
  output logic [DLY_W-1:0] cur_delay,
  output logic             cur_is_zero
);
  localparam logic [DLY_W-1:0] RST_VAL = DLY_W'(RESET_DLY);

  always_ff @(posedge clk) begin
    if (!rst_n)      cur_delay <= RST_VAL;
    else if (wr_en)  cur_delay <= wr_val;
  end

  assign cur_is_zero = (cur_delay == '0);
endmodule

// File: rtl/irqc_window_timer.sv
`timescale 1ns/1ps
module irqc_window_timer #(
  parameter int unsigned DLY_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             tick,
  output logic [DLY_W-1:0] left,
  output logic             expire
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  function automatic logic [DLY_W-1:0] step_down(input logic [DLY_W-1:0] v);
    return (v == '0) ? v : v - ONE;
  endfunction

  // the last tick of a window; a fresh load takes priority
  assign expire = tick && !load && (left == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)      left <= '0;
    else if (load)   left <= load_val;
    else if (tick)   left <= step_down(left);
  end
endmodule

// File: rtl/irqc_merge_count.sv
`timescale 1ns/1ps
module irqc_merge_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  function automatic logic [CNT_W-1:0] sat_bump(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + ONE;
  endfunction

  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    if (clr)      cnt_nx = inc ? ONE : '0;
    else if (inc) cnt_nx = sat_bump(cnt);
    else          cnt_nx = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end
endmodule

// File: rtl/irq_coalesce_timer.sv
`timescale 1ns/1ps
module irq_coalesce_timer
  import irqc_pkg::*;
#(
  parameter int unsigned DLY_W     = 14,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned RESET_DLY = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpl_valid,
  input  logic             cmpl_irq_en,
  input  logic             delay_wr,
  input  logic [DLY_W-1:0] delay_wdata,
  input  logic             us_tick,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [CNT_W-1:0] merged_cnt,
  output logic [DLY_W-1:0] max_delay
);
  localparam logic [DLY_W-1:0] DLY_TOP = DLY_W'(field_top(DLY_W));

  coal_state_e      state, state_nx;
  logic [DLY_W-1:0] cur_delay;
  logic             dly_zero;
  logic [DLY_W-1:0] win_left;

  // named internal events
  logic flag_evt;        // completion that asked for an interrupt
  logic st_idle;
  logic st_armed;
  logic ack_evt;         // acknowledge that is honoured
  logic start_evt;       // a new window opens
  logic zero_start_evt;  // window opens with zero length
  logic expire_evt;      // window ran out on a tick

  assign flag_evt       = cmpl_valid && cmpl_irq_en;
  assign st_idle        = (state == CH_IDLE);
  assign st_armed       = (state == CH_ARMED);
  assign ack_evt        = (state == CH_FIRED) && irq_ack;
  assign start_evt      = flag_evt && (st_idle || ack_evt);
  assign zero_start_evt = start_evt && dly_zero;

  irqc_delay_reg #(.DLY_W(DLY_W), .RESET_DLY(RESET_DLY)) u_dly (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (delay_wr),
    .wr_val      (delay_wdata),
    .cur_delay   (cur_delay),
    .cur_is_zero (dly_zero)
  );

  irqc_window_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_evt),
    .load_val (cur_delay),
    .tick     (us_tick && st_armed),
    .left     (win_left),
    .expire   (expire_evt)
  );

  irqc_merge_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ack_evt),
    .inc   (flag_evt),
    .cnt   (merged_cnt)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      CH_IDLE:  if (start_evt) state_nx = dly_zero ? CH_FIRED : CH_ARMED;
      CH_ARMED: if (expire_evt) state_nx = CH_FIRED;
      CH_FIRED: begin
        if (ack_evt) begin
          if (start_evt) state_nx = dly_zero ? CH_FIRED : CH_ARMED;
          else           state_nx = CH_IDLE;
        end
      end
      default:  state_nx = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= CH_IDLE;
    else        state <= state_nx;
  end

  assign irq_req   = (state == CH_FIRED);
  assign max_delay = DLY_TOP;
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker #(
  parameter int unsigned DLY_W = 14,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flag_evt,
  input logic             us_tick,
  input logic             irq_ack,
  input logic             irq_req,
  input logic [CNT_W-1:0] merged_cnt,
  input logic             start_evt,
  input logic             zero_start_evt,
  input logic             expire_evt,
  input logic [DLY_W-1:0] win_left,
  input logic             st_idle,
  input logic             st_armed
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R4 R6
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(expire_evt || zero_start_evt));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> irq_req);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !flag_evt) |=> (!irq_req && merged_cnt == '0));

  // R9
  ack_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && flag_evt) |=> (merged_cnt == CNT_W'(1)));

  // R3
  unflagged_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && !flag_evt) |=> (st_idle && merged_cnt == '0));

  // R12
  tickless_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_evt && !us_tick) |=> $stable(win_left));

  // R5
  merge_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_armed && flag_evt && merged_cnt != CMAX) |=>
      (merged_cnt == $past(merged_cnt) + CNT_W'(1)));

  // R10
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (merged_cnt == CMAX && !(irq_req && irq_ack)) |=> (merged_cnt == CMAX));
endmodule

bind irq_coalesce_timer irqc_checker #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .flag_evt       (flag_evt),
  .us_tick        (us_tick),
  .irq_ack        (irq_ack),
  .irq_req        (irq_req),
  .merged_cnt     (merged_cnt),
  .start_evt      (start_evt),
  .zero_start_evt (zero_start_evt),
  .expire_evt     (expire_evt),
  .win_left       (win_left),
  .st_idle        (st_idle),
  .st_armed       (st_armed)
);

// File: tb/irq_coalesce_timer_test.sv
`timescale 1ns/1ps
module irq_coalesce_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmpl_valid = 1'b0;
  logic        cmpl_irq_en = 1'b0;
  logic        delay_wr = 1'b0;
  logic [13:0] delay_wdata = '0;
  logic        us_tick = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [7:0]  merged_cnt;
  logic [13:0] max_delay;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_coalesce_timer uut (
    .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_irq_en(cmpl_irq_en),
    .delay_wr(delay_wr), .delay_wdata(delay_wdata), .us_tick(us_tick),
    .irq_ack(irq_ack), .irq_req(irq_req), .merged_cnt(merged_cnt),
    .max_delay(max_delay)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock cycle with the given inputs, applied at a falling edge
  task automatic cyc(input bit v, input bit en, input bit tk, input bit ak);
    cmpl_valid = v; cmpl_irq_en = en; us_tick = tk; irq_ack = ak;
    @(negedge clk);
    cmpl_valid = 0; cmpl_irq_en = 0; us_tick = 0; irq_ack = 0;
  endtask

  task automatic wr_delay(input int d);
    delay_wr = 1; delay_wdata = 14'(d);
    @(negedge clk);
    delay_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 0);
  endtask

  task automatic t_reset;
    check("R1 irq after reset", irq_req, 0);
    check("R1 count after reset", merged_cnt, 0);
    check("R2 max_delay", max_delay, 16383);
  endtask

  task automatic t_zero_delay;
    cyc(1, 1, 0, 0);          // reset delay is 0
    check("R1 R6 irq after flagged completion", irq_req, 1);
    check("R6 count", merged_cnt, 1);
    cyc(0, 0, 0, 1);
    check("R8 irq after ack", irq_req, 0);
    check("R8 count after ack", merged_cnt, 0);
  endtask

  task automatic t_unflagged;
    wr_delay(3);
    cyc(1, 0, 1, 0); cyc(1, 0, 0, 0); ticks(5);
    check("R3 idle irq", irq_req, 0);
    check("R3 idle count", merged_cnt, 0);
    cyc(1, 1, 0, 0);
    cyc(1, 0, 0, 0); cyc(1, 0, 1, 0);
    check("R3 armed count", merged_cnt, 1);
    ticks(2);
    check("R3 irq after window", irq_req, 1);
    cyc(1, 0, 0, 0);
    check("R3 fired count", merged_cnt, 1);
    cyc(0, 0, 0, 1);
  endtask

  task automatic t_window;
    wr_delay(3);
    cyc(1, 1, 1, 0);          // tick in arming cycle is not counted
    check("R4 count after arm", merged_cnt, 1);
    cyc(0, 0, 1, 0);
    cyc(1, 1, 0, 0);
    cyc(0, 0, 1, 0);
    check("R4 irq before last tick", irq_req, 0);
    cyc(1, 1, 0, 0);
    check("R5 count merged", merged_cnt, 3);
    cyc(0, 0, 1, 0);
    check("R4 R5 irq on third tick", irq_req, 1);
    cyc(1, 1, 0, 0);
    check("R5 count while pending", merged_cnt, 4);
    cyc(0, 0, 0, 1);
    check("R8 irq cleared", irq_req, 0);
  endtask

  task automatic t_no_tick;
    wr_delay(2);
    cyc(1, 1, 0, 0);
    cyc(0, 0, 1, 0);
    repeat (50) cyc(0, 0, 0, 0);
    check("R12 no expiry without ticks", irq_req, 0);
    cyc(0, 0, 1, 0);
    check("R12 expiry on tick", irq_req, 1);
    cyc(0, 0, 0, 1);
  endtask

  task automatic t_ack_hold;
    wr_delay(2);
    cyc(0, 0, 0, 1);          // ack while idle
    check("R7 idle ack ignored", irq_req, 0);
    cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 1);          // ack while armed
    check("R7 armed ack keeps count", merged_cnt, 1);
    ticks(2);
    check("R7 window still fires", irq_req, 1);
    repeat (10) cyc(0, 0, 1, 0);
    check("R7 irq held", irq_req, 1);
    check("R7 count held", merged_cnt, 1);
    cyc(0, 0, 0, 1);
  endtask

  task automatic t_ack_same;
    wr_delay(0);
    cyc(1, 1, 0, 0); cyc(1, 1, 0, 0);
    wr_delay(2);
    cyc(1, 1, 0, 1);
    check("R9 new window irq", irq_req, 0);
    check("R9 new window count", merged_cnt, 1);
    ticks(2);
    check("R9 new window fires", irq_req, 1);
    wr_delay(0);
    cyc(1, 1, 0, 1);
    check("R9 zero delay irq stays", irq_req, 1);
    check("R9 zero delay count", merged_cnt, 1);
    cyc(0, 0, 0, 1);
  endtask

  task automatic t_midwrite;
    wr_delay(4);
    cyc(1, 1, 0, 0);
    wr_delay(1);
    ticks(3);
    check("R11 old delay still used", irq_req, 0);
    ticks(1);
    check("R11 fires at old delay", irq_req, 1);
    cyc(0, 0, 0, 1);
    cyc(1, 1, 0, 0);
    ticks(1);
    check("R11 next window uses new delay", irq_req, 1);
    cyc(0, 0, 0, 1);
  endtask

  task automatic t_saturate;
    wr_delay(0);
    repeat (300) cyc(1, 1, 0, 0);
    check("R10 saturated count", merged_cnt, 255);
    cyc(0, 0, 0, 1);
    check("R10 cleared after saturation", merged_cnt, 0);
  endtask

  task automatic t_max_delay;
    wr_delay(16383);
    cyc(1, 1, 0, 0);
    ticks(16382);
    check("R4 max delay before end", irq_req, 0);
    ticks(1);
    check("R4 max delay fires", irq_req, 1);
    cyc(0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_zero_delay();
    t_unflagged();
    t_window();
    t_no_tick();
    t_ack_hold();
    t_ack_same();
    t_midwrite();
    t_saturate();
    t_max_delay();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule